// File: doc/BRIEF.md
# Flash Boot-Sector Probe and Record Loader

This block sits behind a flash read engine during boot. On a start pulse it asks the engine for sector 0 using access method 0 and examines the first four bytes of the returned 512-byte stream for a fixed signature. If they do not match, it drains the rest of that sector and asks again with the next method, up to method 5. The first method that yields the signature is kept. From that sector's 16-byte header the block takes the flash type, the block-size and flash-size exponents, the access time and a count of extra sectors. The count is honoured only when an optional boot tag is present.

From byte 16 onward, the loaded data (the first sector plus any extra sectors, requested in turn with the kept method) is read as a sequence of big-endian 16-bit words forming boot records. A record consists of a type word, a length word holding the element count minus one, a target address and the data. Records that target instruction memory or one of the two data memories are turned into writes on a memory port. An execute record ends the boot and reports its start address. An unknown type word ends the boot with an abort status. A record that cannot fit in the data still to come ends it with an overrun status.

Top module: `bsp_boot_parser`

## Requirements
- R1: After reset, status is 0 (idle), rd_req and mem_we are low, and flash_type, blk_exp, size_exp, acc_ns and exec_addr are 0.
- R2: With strap_ce high, a start issues read requests for sector 0 with rd_method 0, 1, 2, ... in order, each after the previous sector's 512 bytes. Probing stops at the first method whose bytes 0..3 equal the signature 5A A5 C3 3C. A sector that matches in only three of the four bytes counts as a miss.
- R3: If strap_ce is low at start, no read is requested. If all six methods miss, probing ends. In both cases status becomes 5 (no flash), flash_type becomes 0xFFFF and no memory write occurs.
- R4: Header fields are big-endian: flash_type from bytes 4..5, blk_exp from byte 6, size_exp from byte 7, acc_ns from bytes 8..9.
- R5: When bytes 12..15 equal 7E 57 B0 07, the count N in bytes 10..11 loads N+1 sectors (sectors 1..N are requested in order with the kept method). Otherwise only sector 0 is loaded, and a count of 0 also means sector 0 only.
- R6: Records start at byte 16. Words are formed high byte first. Type 0x8001 writes data memory X (mem_space 1) and type 0x8002 writes data memory Y (mem_space 2). Each data word becomes one write with the word in mem_wdata[15:0], zero above, at the record address plus the element index. The length word is the element count minus one.
- R7: Type 0x8000 writes instruction memory (mem_space 0). Each element is two consecutive words, combined as {first, second} into mem_wdata, at consecutive addresses. Records may cross sector boundaries.
- R8: Type 0x8003 (type, length, address) sets status 2 and exec_addr to its address word. Later bytes cause no writes, and status holds until the next start.
- R9: Any other type word sets status 3 (abort) at once. No write follows it.
- R10: If a record's length word implies more words than remain in the loaded data, status becomes 4 (overrun) with no write from that record. Running out of loaded data before an execute record also gives status 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a boot attempt (taken when idle or finished) |
| strap_ce | input | 1 | Flash-present strap; low skips the probe |
| rd_req | output | 1 | One-cycle sector read request |
| rd_method | output | 3 | Access method index for the request |
| rd_sector | output | 16 | Sector number for the request |
| byte_valid | input | 1 | Stream byte present this cycle |
| byte_data | input | 8 | Stream byte |
| mem_we | output | 1 | Memory write strobe |
| mem_space | output | 2 | 0 instruction, 1 X data, 2 Y data |
| mem_addr | output | 16 | Write address |
| mem_wdata | output | 32 | Write data |
| status | output | 3 | 0 idle, 1 busy, 2 execute, 3 abort, 4 overrun, 5 no flash |
| flash_type | output | 16 | Flash type from header, 0xFFFF when none |
| blk_exp | output | 8 | Block-size exponent |
| size_exp | output | 8 | Flash-size exponent |
| acc_ns | output | 16 | Access time in ns |
| exec_addr | output | 16 | Start address from the execute record |

## Verification
The bench presents near-miss signatures on every rejected method. A design that compared fewer bytes would lock onto the wrong method and issue the wrong request sequence. It sets an extra-sector count both with and without the tag, so a block that ignored the tag gate would request extra sectors or miss the execute record. Instruction and data records straddle sector boundaries, which exposes faulty word pairing or address stepping. Length words are chosen so that one record fits exactly to the final byte and another overshoots: an off-by-one overrun test would either write a partial record or report overrun too early. Records placed after execute and abort words show whether the block keeps writing once it should have stopped.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_BUSY  = 3'd1,
        ST_EXEC  = 3'd2,
        ST_ABORT = 3'd3,
        ST_OVER  = 3'd4,
        ST_NONE  = 3'd5
    } status_e;

    typedef enum logic [1:0] {
        SP_I = 2'd0,
        SP_X = 2'd1,
        SP_Y = 2'd2
    } space_e;

    typedef enum logic [1:0] {
        T_IDLE,
        T_HDR,
        T_SKIP,
        T_REC
    } phase_e;

    typedef enum logic [2:0] {
        R_TYPE,
        R_LEN,
        R_ADDR,
        R_IHI,
        R_DATA,
        R_STOP
    } walk_e;

    localparam logic [15:0] CODE_IMEM = 16'h8000;
    localparam logic [15:0] CODE_XMEM = 16'h8001;
    localparam logic [15:0] CODE_YMEM = 16'h8002;
    localparam logic [15:0] CODE_EXEC = 16'h8003;

endpackage

// File: rtl/bsp_hdr_shift.sv
module bsp_hdr_shift (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  byte_i,
    output logic [31:0] last4,
    output logic [15:0] f_type,
    output logic [7:0]  f_blk,
    output logic [7:0]  f_size,
    output logic [15:0] f_ns,
    output logic [15:0] f_cnt,
    output logic [31:0] f_tag
);
    // 15 previous bytes plus the current one form the whole header
    logic [119:0] sh_d, sh_q;
    logic [127:0] full;

    always_comb begin
        sh_d = sh_q;
        if (clr)
            sh_d = '0;
        else if (en)
            sh_d = {sh_q[111:0], byte_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // byte k of the header lands at full[127-8k -: 8] on header byte 15
    assign full   = {sh_q, byte_i};
    assign last4  = full[31:0];
    assign f_type = full[95:80];
    assign f_blk  = full[79:72];
    assign f_size = full[71:64];
    assign f_ns   = full[63:48];
    assign f_cnt  = full[47:32];
    assign f_tag  = full[31:0];
endmodule

// File: rtl/bsp_rec_walk.sv
module bsp_rec_walk
    import bsp_pkg::*;
#(
    parameter int LW = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [7:0]    byte_i,
    input  logic          odd,
    input  logic [LW-1:0] left,
    output logic          ev_exec,
    output logic          ev_abort,
    output logic          ev_over,
    output logic [15:0]   ev_addr,
    output logic          we,
    output logic [1:0]    wspace,
    output logic [15:0]   waddr,
    output logic [31:0]   wdata
);
    typedef struct packed {
        walk_e       st;
        logic [7:0]  hi;
        space_e      sp;
        logic        ex;
        logic [16:0] cnt;
        logic [15:0] addr;
        logic [15:0] ihi;
        logic        we;
        space_e      wsp;
        logic [15:0] waddr;
        logic [31:0] wdata;
    } walk_s;

    walk_s q, n;
    logic [15:0]   w;
    logic [16:0]   elems;
    logic [17:0]   dw;
    logic [18:0]   need;
    logic [LW-1:0] need_b;

    always_comb begin
        n        = q;
        n.we     = 1'b0;
        ev_exec  = 1'b0;
        ev_abort = 1'b0;
        ev_over  = 1'b0;
        w        = {q.hi, byte_i};
        ev_addr  = w;
        elems    = {1'b0, w} + 17'd1;
        dw       = (q.sp == SP_I) ? {elems, 1'b0} : {1'b0, elems};
        need     = q.ex ? 19'd1 : ({1'b0, dw} + 19'd1);
        need_b   = LW'({need, 1'b0});
        if (clr) begin
            n.st = R_TYPE;
        end else if (en) begin
            if (!odd) begin
                n.hi = byte_i;
            end else begin
                case (q.st)
                    R_TYPE: begin
                        n.ex = 1'b0;
                        n.st = R_LEN;
                        case (w)
                            CODE_IMEM: n.sp = SP_I;
                            CODE_XMEM: n.sp = SP_X;
                            CODE_YMEM: n.sp = SP_Y;
                            CODE_EXEC: n.ex = 1'b1;
                            default: begin
                                ev_abort = 1'b1;
                                n.st     = R_STOP;
                            end
                        endcase
                    end
                    R_LEN: begin
                        if (need_b > left) begin
                            ev_over = 1'b1;
                            n.st    = R_STOP;
                        end else begin
                            n.cnt = elems;
                            n.st  = R_ADDR;
                        end
                    end
                    R_ADDR: begin
                        if (q.ex) begin
                            ev_exec = 1'b1;
                            n.st    = R_STOP;
                        end else begin
                            n.addr = w;
                            n.st   = (q.sp == SP_I) ? R_IHI : R_DATA;
                        end
                    end
                    R_IHI: begin
                        n.ihi = w;
                        n.st  = R_DATA;
                    end
                    R_DATA: begin
                        n.we    = 1'b1;
                        n.wsp   = q.sp;
                        n.waddr = q.addr;
                        n.wdata = (q.sp == SP_I) ? {q.ihi, w} : {16'h0000, w};
                        n.addr  = q.addr + 16'd1;
                        n.cnt   = q.cnt - 17'd1;
                        if (q.cnt == 17'd1)     n.st = R_TYPE;
                        else if (q.sp == SP_I)  n.st = R_IHI;
                        else                    n.st = R_DATA;
                    end
                    default: n.st = R_STOP;
                endcase
            end
            // loaded data exhausted without an execute record
            if (left == '0 && n.st != R_STOP && q.st != R_STOP) begin
                ev_over = 1'b1;
                n.st    = R_STOP;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= R_STOP;
        end else begin
            q <= n;
        end
    end

    assign we     = q.we;
    assign wspace = q.wsp;
    assign waddr  = q.addr - 16'd1;
    assign wdata  = q.wdata;

    // R6: a write needs two stream bytes, so strobes never come back to back
    assert_write_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q.we |=> !q.we);
    // R6: every write answers a byte accepted in the cycle before
    assert_write_follows_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q.we |-> $past(en && odd));
    // R9: nothing is written after an abort event
    assert_no_write_after_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_abort |=> !q.we);
endmodule

// File: rtl/bsp_boot_parser.sv
module bsp_boot_parser
    import bsp_pkg::*;
#(
    parameter logic [31:0] SIG         = 32'h5AA5C33C,
    parameter logic [31:0] TAG         = 32'h7E57B007,
    parameter int          NUM_METHODS = 6,
    parameter int          SEC_W       = 16,
    parameter int          SECT_BITS   = 9
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic                           strap_ce,
    output logic                           rd_req,
    output logic [$clog2(NUM_METHODS)-1:0] rd_method,
    output logic [SEC_W-1:0]               rd_sector,
    input  logic                           byte_valid,
    input  logic [7:0]                     byte_data,
    output logic                           mem_we,
    output logic [1:0]                     mem_space,
    output logic [15:0]                    mem_addr,
    output logic [31:0]                    mem_wdata,
    output logic [2:0]                     status,
    output logic [15:0]                    flash_type,
    output logic [7:0]                     blk_exp,
    output logic [7:0]                     size_exp,
    output logic [15:0]                    acc_ns
    ,output logic [15:0]                   exec_addr
);
    localparam int M_W = $clog2(NUM_METHODS);
    localparam int LW  = SEC_W + SECT_BITS;
    localparam logic [M_W-1:0]       M_ONE   = 1;
    localparam logic [M_W-1:0]       M_LAST  = M_W'(NUM_METHODS - 1);
    localparam logic [SECT_BITS-1:0] P_ONE   = 1;
    localparam logic [SECT_BITS-1:0] P_SIG   = 3;
    localparam logic [SECT_BITS-1:0] P_HDR   = 15;
    localparam logic [SECT_BITS-1:0] P_LAST  = '1;
    localparam logic [SEC_W-1:0]     S_ONE   = 1;

    typedef struct packed {
        phase_e               st;
        logic [M_W-1:0]       meth;
        logic [SEC_W-1:0]     sect;
        logic [SECT_BITS-1:0] pos;
        logic [SEC_W-1:0]     more;
        logic                 req;
        status_e              stat;
        logic [15:0]          ftype;
        logic [7:0]           blk;
        logic [7:0]           size;
        logic [15:0]          ns;
        logic [15:0]          xaddr;
    } top_s;

    top_s q, d;

    logic        hdr_en, rec_en, rec_clr, go;
    logic [31:0] last4, f_tag;
    logic [15:0] f_type, f_ns, f_cnt, ev_addr;
    logic [7:0]  f_blk, f_size;
    logic        ev_exec, ev_abort, ev_over;
    logic [LW-1:0] left;

    assign go      = start && (q.st == T_IDLE);
    assign hdr_en  = byte_valid && (q.st == T_HDR);
    assign rec_en  = byte_valid && (q.st == T_REC);
    // bytes still to come after the current one: whole sectors plus rest of this
    assign left    = {q.more, ~q.pos};

    bsp_hdr_shift u_hdr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (go),
        .en     (hdr_en),
        .byte_i (byte_data),
        .last4  (last4),
        .f_type (f_type),
        .f_blk  (f_blk),
        .f_size (f_size),
        .f_ns   (f_ns),
        .f_cnt  (f_cnt),
        .f_tag  (f_tag)
    );

    bsp_rec_walk #(.LW(LW)) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rec_clr),
        .en       (rec_en),
        .byte_i   (byte_data),
        .odd      (q.pos[0]),
        .left     (left),
        .ev_exec  (ev_exec),
        .ev_abort (ev_abort),
        .ev_over  (ev_over),
        .ev_addr  (ev_addr),
        .we       (mem_we),
        .wspace   (mem_space),
        .waddr    (mem_addr),
        .wdata    (mem_wdata)
    );

    always_comb begin
        d       = q;
        d.req   = 1'b0;
        rec_clr = 1'b0;
        case (q.st)
            T_IDLE: begin
                if (start) begin
                    d.ftype = '0;
                    d.blk   = '0;
                    d.size  = '0;
                    d.ns    = '0;
                    d.xaddr = '0;
                    if (!strap_ce) begin
                        d.stat  = ST_NONE;
                        d.ftype = 16'hFFFF;
                    end else begin
                        d.stat = ST_BUSY;
                        d.meth = '0;
                        d.sect = '0;
                        d.pos  = '0;
                        d.more = '0;
                        d.req  = 1'b1;
                        d.st   = T_HDR;
                    end
                end
            end
            T_HDR: begin
                if (byte_valid) begin
                    d.pos = q.pos + P_ONE;
                    if (q.pos == P_SIG && last4 != SIG) begin
                        d.st = T_SKIP;
                    end else if (q.pos == P_HDR) begin
                        d.ftype = f_type;
                        d.blk   = f_blk;
                        d.size  = f_size;
                        d.ns    = f_ns;
                        d.more  = (f_tag == TAG) ? f_cnt : '0;
                        d.st    = T_REC;
                        rec_clr = 1'b1;
                    end
                end
            end
            T_SKIP: begin
                if (byte_valid) begin
                    d.pos = q.pos + P_ONE;
                    if (q.pos == P_LAST) begin
                        if (q.meth == M_LAST) begin
                            d.stat  = ST_NONE;
                            d.ftype = 16'hFFFF;
                            d.st    = T_IDLE;
                        end else begin
                            d.meth = q.meth + M_ONE;
                            d.req  = 1'b1;
                            d.st   = T_HDR;
                        end
                    end
                end
            end
            T_REC: begin
                if (byte_valid) begin
                    d.pos = q.pos + P_ONE;
                    if (ev_exec) begin
                        d.stat  = ST_EXEC;
                        d.xaddr = ev_addr;
                        d.st    = T_IDLE;
                    end else if (ev_abort) begin
                        d.stat = ST_ABORT;
                        d.st   = T_IDLE;
                    end else if (ev_over) begin
                        d.stat = ST_OVER;
                        d.st   = T_IDLE;
                    end else if (q.pos == P_LAST && q.more != '0) begin
                        d.more = q.more - S_ONE;
                        d.sect = q.sect + S_ONE;
                        d.req  = 1'b1;
                    end
                end
            end
            default: d.st = T_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_req     = q.req;
    assign rd_method  = q.meth;
    assign rd_sector  = q.sect;
    assign status     = q.stat;
    assign flash_type = q.ftype;
    assign blk_exp    = q.blk;
    assign size_exp   = q.size;
    assign acc_ns     = q.ns;
    assign exec_addr  = q.xaddr;

    // R2: requests are single-cycle pulses
    assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);
    // R2: only the defined access methods are ever requested
    assert_method_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_method <= M_LAST));
    // R3: a low strap never leads to a read
    assert_strap_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !strap_ce && q.st == T_IDLE) |=> !rd_req);
    // R3: the no-flash result always carries the all-ones type
    assert_none_type_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (status == ST_NONE) |-> (flash_type == 16'hFFFF));
    // R8: a final result holds until the next start
    assert_result_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((status inside {ST_EXEC, ST_ABORT, ST_OVER, ST_NONE}) && !start) |=> $stable(status));
endmodule

// File: tb/test_bsp_boot_parser.sv
module test_bsp_boot_parser;

    localparam logic [31:0] SIG = 32'h5AA5C33C;
    localparam logic [31:0] TAG = 32'h7E57B007;

    // {strap, good method (7 = none), expected status}
    localparam logic [6:0] VEC [0:9] = '{
        7'b1_000_010, 7'b1_011_010, 7'b1_101_010, 7'b1_111_101, 7'b0_000_101,
        7'b1_001_010, 7'b1_010_100, 7'b1_000_011, 7'b1_100_100, 7'b1_000_010
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        strap_ce = 1'b0;
    logic        rd_req;
    logic [2:0]  rd_method;
    logic [15:0] rd_sector;
    logic        byte_valid;
    logic [7:0]  byte_data;
    logic        mem_we;
    logic [1:0]  mem_space;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [2:0]  status;
    logic [15:0] flash_type;
    logic [7:0]  blk_exp, size_exp;
    logic [15:0] acc_ns, exec_addr;

    always #5 clk = ~clk;

    bsp_boot_parser i_bsp_boot_parser (
        .clk(clk), .rst_n(rst_n), .start(start), .strap_ce(strap_ce),
        .rd_req(rd_req), .rd_method(rd_method), .rd_sector(rd_sector),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .mem_we(mem_we), .mem_space(mem_space), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .status(status), .flash_type(flash_type), .blk_exp(blk_exp), .size_exp(size_exp),
        .acc_ns(acc_ns), .exec_addr(exec_addr)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0]  img [0:2047];
    int          good_m;
    int          ptr;
    int          nsec;
    logic [15:0] x_exec;
    logic [1:0]  e_sp [0:1023];
    logic [15:0] e_ad [0:1023];
    logic [31:0] e_da [0:1023];
    int          n_exp;
    logic [1:0]  g_sp [0:1023];
    logic [15:0] g_ad [0:1023];
    logic [31:0] g_da [0:1023];
    int          n_got;
    logic [2:0]  q_m [0:31];
    logic [15:0] q_s [0:31];
    int          n_rq;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // flash read engine model
    initial begin
        byte_valid = 1'b0;
        byte_data  = 8'h00;
        @(negedge clk);
        forever begin
            if (rd_req === 1'b1) begin
                automatic int m = rd_method;
                automatic int s = rd_sector;
                for (int i = 0; i < 512; i++) begin
                    byte_valid = 1'b1;
                    if (m == good_m)
                        byte_data = (s < 4) ? img[s*512+i] : 8'hFF;
                    else if (s == 0)
                        byte_data = (i == 3) ? (img[3] ^ 8'h01) : img[i];
                    else
                        byte_data = 8'hFF;
                    @(negedge clk);
                end
                byte_valid = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    end

    // output monitors
    always @(negedge clk) begin
        if (rst_n && mem_we === 1'b1 && n_got < 1024) begin
            g_sp[n_got] = mem_space;
            g_ad[n_got] = mem_addr;
            g_da[n_got] = mem_wdata;
            n_got++;
        end
        if (rst_n && rd_req === 1'b1 && n_rq < 32) begin
            q_m[n_rq] = rd_method;
            q_s[n_rq] = rd_sector;
            n_rq++;
        end
    end

    task automatic pw(input logic [15:0] wd);
        img[ptr]   = wd[15:8];
        img[ptr+1] = wd[7:0];
        ptr += 2;
    endtask

    task automatic put_rec(input logic [15:0] code, input logic [15:0] addr, input int n,
                           input logic [15:0] seed, input bit logit);
        pw(code);
        pw(16'(n - 1));
        pw(addr);
        for (int k = 0; k < n; k++) begin
            automatic logic [15:0] hi = seed + 16'(2*k);
            automatic logic [15:0] lo = seed + 16'(2*k + 1);
            if (code == 16'h8000) begin
                pw(hi);
                pw(lo);
            end else begin
                pw(hi);
            end
            if (logit) begin
                e_sp[n_exp] = code[1:0];
                e_ad[n_exp] = addr + 16'(k);
                e_da[n_exp] = (code == 16'h8000) ? {hi, lo} : {16'h0000, hi};
                n_exp++;
            end
        end
    endtask

    task automatic put_exec(input logic [15:0] addr);
        pw(16'h8003);
        pw(16'h0000);
        pw(addr);
        x_exec = addr;
    endtask

    task automatic build(input int sc);
        automatic bit          tag_on = 1'b0;
        automatic logic [15:0] cnt = 16'h0;
        for (int i = 0; i < 2048; i++) img[i] = 8'h00;
        n_exp = 0;
        x_exec = 16'h0;
        case (sc)
            2:       begin tag_on = 1'b1; cnt = 16'd0; end
            5:       begin tag_on = 1'b1; cnt = 16'd2; end
            6:       begin tag_on = 1'b0; cnt = 16'd2; end
            8:       begin tag_on = 1'b0; cnt = 16'd3; end
            9:       begin tag_on = 1'b1; cnt = 16'd1; end
            default: begin tag_on = 1'b0; cnt = 16'd0; end
        endcase
        {img[0], img[1], img[2], img[3]} = SIG;
        {img[4], img[5]} = 16'h0100 + 16'(sc);
        img[6] = 8'h08 + 8'(sc);
        img[7] = 8'h20 + 8'(sc);
        {img[8], img[9]} = 16'h0294;
        {img[10], img[11]} = cnt;
        {img[12], img[13], img[14], img[15]} = tag_on ? TAG : ~TAG;
        nsec = tag_on ? int'(cnt) + 1 : 1;
        ptr = 16;
        case (sc)
            0: begin
                put_rec(16'h8001, 16'h0100, 3, 16'h1000, 1'b1);
                put_exec(16'h4000);
                put_rec(16'h8002, 16'h0500, 2, 16'h9000, 1'b0);
            end
            1: begin
                put_rec(16'h8002, 16'h0040, 2, 16'h2200, 1'b1);
                put_rec(16'h8000, 16'h0800, 2, 16'hA000, 1'b1);
                put_exec(16'h4001);
            end
            2: begin
                put_rec(16'h8001, 16'h7FFF, 1, 16'h3300, 1'b1);
                put_exec(16'h4002);
            end
            4: put_exec(16'h4004);
            5: begin
                put_rec(16'h8001, 16'h1000, 400, 16'h0001, 1'b1);
                put_rec(16'h8002, 16'h2000, 300, 16'h5000, 1'b1);
                put_exec(16'h4005);
            end
            6: put_rec(16'h8001, 16'h1000, 400, 16'h0001, 1'b0);
            7: begin
                put_rec(16'h8001, 16'h0200, 2, 16'h6600, 1'b1);
                pw(16'h8004);
                put_rec(16'h8001, 16'h0300, 2, 16'h7700, 1'b0);
            end
            8: put_rec(16'h8001, 16'h0000, 245, 16'h0100, 1'b1);
            9: begin
                put_rec(16'h8000, 16'h0010, 130, 16'hC000, 1'b1);
                put_exec(16'h4009);
            end
            default: ;
        endcase
    endtask

    function automatic string st_tag(input int sc);
        case (sc)
            0: return "R8";
            1: return "R7";
            2: return "R5";
            3: return "R2";
            4: return "R3";
            5: return "R5";
            6: return "R10";
            7: return "R9";
            8: return "R10";
            default: return "R7";
        endcase
    endfunction

    task automatic run(input int sc);
        automatic bit   strap = VEC[sc][6];
        automatic int   gm    = int'(VEC[sc][5:3]);
        automatic logic [2:0] est = VEC[sc][2:0];
        automatic int   erq;
        automatic bit   ok;
        build(sc);
        good_m = gm;
        n_got = 0;
        n_rq = 0;
        strap_ce = strap;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < 20000; t++) begin
            if (status != 3'd1 && status != 3'd0) break;
            @(negedge clk);
        end
        repeat (600) @(negedge clk);

        chk(status == est, st_tag(sc), $sformatf("status sc%0d", sc), status, est);
        chk(flash_type == ((est == 3'd5) ? 16'hFFFF : 16'h0100 + 16'(sc)),
            (est == 3'd5) ? "R3" : "R4", $sformatf("flash_type sc%0d", sc),
            flash_type, (est == 3'd5) ? 16'hFFFF : 16'h0100 + 16'(sc));
        if (est == 3'd2)
            chk(exec_addr == x_exec, "R8", $sformatf("exec_addr sc%0d", sc), exec_addr, x_exec);

        // expected read requests
        if (!strap) erq = 0;
        else if (gm == 7) erq = 6;
        else erq = gm + nsec;
        ok = (n_rq == erq);
        for (int k = 0; k < erq && k < n_rq; k++) begin
            if (gm == 7 || k <= gm) begin
                if (q_m[k] != 3'(k) || q_s[k] != 16'd0) ok = 1'b0;
            end else begin
                if (q_m[k] != 3'(gm) || q_s[k] != 16'(k - gm)) ok = 1'b0;
            end
        end
        chk(ok, (sc == 5 || sc == 9 || sc == 2) ? "R5" : "R2",
            $sformatf("request sequence sc%0d (count)", sc), n_rq, erq);

        // expected writes
        ok = (n_got == n_exp);
        for (int k = 0; k < n_exp && k < n_got; k++) begin
            if (g_sp[k] != e_sp[k] || g_ad[k] != e_ad[k] || g_da[k] != e_da[k]) begin
                if (ok)
                    $display("FAIL %s write %0d sc%0d: actual %0h/%0h/%0h expected %0h/%0h/%0h",
                             st_tag(sc), k, sc, g_sp[k], g_ad[k], g_da[k],
                             e_sp[k], e_ad[k], e_da[k]);
                ok = 1'b0;
            end
        end
        chk(ok, (sc == 1 || sc == 9) ? "R7" : "R6",
            $sformatf("write log sc%0d (count)", sc), n_got, n_exp);

        if (sc == 0) begin
            chk(blk_exp == 8'h08, "R4", "blk_exp", blk_exp, 8'h08);
            chk(size_exp == 8'h20, "R4", "size_exp", size_exp, 8'h20);
            chk(acc_ns == 16'h0294, "R4", "acc_ns big-endian", acc_ns, 16'h0294);
        end
        if (sc == 6)
            chk(n_got == 0, "R10", "no write from overrunning record", n_got, 0);
        if (sc == 7)
            chk(n_got == 2, "R9", "writes stop at unknown type", n_got, 2);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        good_m = 0;
        n_got = 0;
        n_rq = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(status == 3'd0, "R1", "status after reset", status, 0);
        chk(rd_req == 1'b0, "R1", "rd_req after reset", rd_req, 0);
        chk(mem_we == 1'b0, "R1", "mem_we after reset", mem_we, 0);
        chk(flash_type == 16'h0 && exec_addr == 16'h0 && acc_ns == 16'h0,
            "R1", "fields after reset", flash_type, 0);

        for (int sc = 0; sc < 10; sc++) run(sc);

        // R8: result held while no start arrives
        repeat (50) @(negedge clk);
        chk(status == 3'd2, "R8", "status held after finish", status, 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule